// File: doc/BRIEF.md
# I2S Stereo DAC Transmitter

This block drives an external serial stereo audio converter from a single system clock. One free-running binary counter produces every timing signal. A master clock at one quarter of the system clock is taken from bit 1 and inverted. The bit clock is bit 4, which divides the system clock by 32. The word-select clock is bit 9, which divides the system clock by 1024. With a 50 MHz system clock these give 12.5 MHz, about 1.56 MHz and about 48.8 kHz. The master clock therefore runs at 256 times the sample rate, and the bit clock runs at 32 times the sample rate.

Two signed 16-bit sample words, left and right, are captured into holding registers once per frame. A one-cycle frame strobe tells an upstream generator when that capture happens. A single shift register serializes the words MSB first in the standard I2S framing: the MSB of each channel follows the word-select edge by one bit-clock period. The register is loaded and shifted only on system-clock edges where the bit clock falls, so the data line is stable at every rising edge of the bit clock, where the converter samples it.

Each cycle a decoder picks one of four serializer operations from the counter strobes. SER_HOLD keeps the register between bit-clock falls. SER_SHIFT shifts one place left and fills with zero. SER_LOAD_L loads the held left word. SER_LOAD_R loads the held right word. The counter is the only sequencing state. It advances through a frame position p = 0..1023 and wraps from 1023 to 0. Transitions happen at fixed positions: p=31→32 loads the left word, p=543→544 loads the right word, and every other wrap of the low five counter bits is a shift.

Top module: `i2s_tx`

## Requirements
- R1: A synchronous reset clears the counter, the holding registers and the shift register. While reset is held and on the first cycle after it: mclk_o=1, bclk_o=0, ws_o=0, sdata_o=0 and frame_tick_o=1 (frame position p=0, where p is the number of clocks since reset modulo 1024).
- R2: bclk_o equals bit 4 of p. It is low for 16 system clocks and then high for 16, a division by 32.
- R3: mclk_o equals the inverse of bit 1 of p. It is high for 2 clocks and then low for 2, a division by 4.
- R4: ws_o equals bit 9 of p. It is low (left channel) for p<512 and high (right channel) for p>=512.
- R5: For 32<=p<544, sdata_o is bit 15-(p-32)/32 of the left word captured in the current frame, MSB first. The MSB appears one bit-clock period after ws_o falls.
- R6: For p>=544, sdata_o is bit 15-(p-544)/32 of the right word captured in the current frame. During p=0..31 of the following frame, sdata_o is bit 0 of that right word.
- R7: sdata_o changes only on a clock where bclk_o goes from 1 to 0.
- R8: frame_tick_o is high exactly when p=0. left_i and right_i are captured only at the clock edge that ends that cycle. Values present at any other edge have no effect on sdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| left_i | input | 16 | Signed left-channel sample |
| right_i | input | 16 | Signed right-channel sample |
| mclk_o | output | 1 | Master clock, system clock / 4 |
| bclk_o | output | 1 | Bit clock, system clock / 32 |
| ws_o | output | 1 | Word select, low = left, high = right |
| sdata_o | output | 1 | Serial data, MSB first |
| frame_tick_o | output | 1 | One-cycle strobe at frame position 0 |

## Verification
The left and right words are set to asymmetric constants: the left word has only its MSB set and the right word has only its LSB set. This shows whether each load happens one bit period late or early, and whether the right word's LSB carries over into the next frame. Alternating-bit patterns and an all-ones / all-zero pair show whether bit order or channel order is swapped. A phase where both inputs change on every cycle shows whether the design captures anywhere other than the frame strobe. A reset asserted in the middle of a frame shows that the counter and the data line return to their initial state.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    // Serializer operation chosen each system clock
    typedef enum logic [1:0] {
        SER_HOLD   = 2'd0,
        SER_SHIFT  = 2'd1,
        SER_LOAD_L = 2'd2,
        SER_LOAD_R = 2'd3
    } ser_op_e;

    localparam int NUM_CH = 2;
    localparam int CH_L   = 0;
    localparam int CH_R   = 1;

endpackage

// File: rtl/i2s_clkgen.sv
module i2s_clkgen #(
    parameter int SAMPLE_W = 16,
    parameter int MCLK_TAP = 1,
    parameter int BCLK_TAP = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic mclk_o,
    output logic bclk_o,
    output logic ws_o,
    output logic bfall_o,
    output logic load_l_o,
    output logic load_r_o,
    output logic frame_o
);
    localparam int BCLK_PER = 2 ** (BCLK_TAP + 1);
    localparam int WS_TAP   = BCLK_TAP + 1 + $clog2(SAMPLE_W);
    localparam int CNT_W    = WS_TAP + 1;
    localparam int HALF     = 2 ** WS_TAP;
    localparam logic [CNT_W-1:0] LOAD_L_AT = CNT_W'(BCLK_PER - 1);
    localparam logic [CNT_W-1:0] LOAD_R_AT = CNT_W'(HALF + BCLK_PER - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        mclk_o   = ~cnt_q[MCLK_TAP];
        bclk_o   = cnt_q[BCLK_TAP];
        ws_o     = cnt_q[WS_TAP];
        bfall_o  = &cnt_q[BCLK_TAP:0];
        load_l_o = (cnt_q == LOAD_L_AT);
        load_r_o = (cnt_q == LOAD_R_AT);
        frame_o  = (cnt_q == '0);
    end

    // R3
    mclk_half_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(mclk_o) |=> $stable(mclk_o));
    // R5
    load_left_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_l_o |-> (!ws_o && bfall_o));
    // R6
    load_right_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_r_o |-> (ws_o && bfall_o));
    // R8
    frame_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_o |=> !frame_o);

endmodule

// File: rtl/i2s_frame_latch.sv
module i2s_frame_latch
    import i2s_tx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                cap_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic [SAMPLE_W-1:0] hold_l_o,
    output logic [SAMPLE_W-1:0] hold_r_o
);
    logic [SAMPLE_W-1:0] in_w   [NUM_CH];
    logic [SAMPLE_W-1:0] hold_q [NUM_CH];

    assign in_w[CH_L] = left_i;
    assign in_w[CH_R] = right_i;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk_i) begin
            if (rst_i)      hold_q[ch] <= '0;
            else if (cap_i) hold_q[ch] <= in_w[ch];
        end

        // R8
        hold_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !cap_i |=> $stable(hold_q[ch]));
    end

    assign hold_l_o = hold_q[CH_L];
    assign hold_r_o = hold_q[CH_R];

endmodule

// File: rtl/i2s_serializer.sv
module i2s_serializer
    import i2s_tx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                bfall_i,
    input  logic                load_l_i,
    input  logic                load_r_i,
    input  logic [SAMPLE_W-1:0] word_l_i,
    input  logic [SAMPLE_W-1:0] word_r_i,
    output logic                sdata_o
);
    localparam int MSB = SAMPLE_W - 1;

    ser_op_e             op;
    logic [SAMPLE_W-1:0] sreg_q;

    always_comb begin
        if (load_l_i)      op = SER_LOAD_L;
        else if (load_r_i) op = SER_LOAD_R;
        else if (bfall_i)  op = SER_SHIFT;
        else               op = SER_HOLD;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sreg_q <= '0;
        end else begin
            unique case (op)
                SER_HOLD:   sreg_q <= sreg_q;
                SER_SHIFT:  sreg_q <= {sreg_q[MSB-1:0], 1'b0};
                SER_LOAD_L: sreg_q <= word_l_i;
                SER_LOAD_R: sreg_q <= word_r_i;
            endcase
        end
    end

    assign sdata_o = sreg_q[MSB];

    // R5
    msb_left_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_l_i |=> (sdata_o == $past(word_l_i[MSB])));
    // R6
    msb_right_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_r_i |=> (sdata_o == $past(word_r_i[MSB])));

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx #(
    parameter int SAMPLE_W = 16,
    parameter int MCLK_TAP = 1,
    parameter int BCLK_TAP = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                mclk_o,
    output logic                bclk_o,
    output logic                ws_o,
    output logic                sdata_o,
    output logic                frame_tick_o
);
    logic                bfall, load_l, load_r, frame;
    logic [SAMPLE_W-1:0] hold_l, hold_r;

    i2s_clkgen #(
        .SAMPLE_W (SAMPLE_W),
        .MCLK_TAP (MCLK_TAP),
        .BCLK_TAP (BCLK_TAP)
    ) u_clkgen (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .mclk_o   (mclk_o),
        .bclk_o   (bclk_o),
        .ws_o     (ws_o),
        .bfall_o  (bfall),
        .load_l_o (load_l),
        .load_r_o (load_r),
        .frame_o  (frame)
    );

    i2s_frame_latch #(.SAMPLE_W(SAMPLE_W)) u_latch (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cap_i    (frame),
        .left_i   (left_i),
        .right_i  (right_i),
        .hold_l_o (hold_l),
        .hold_r_o (hold_r)
    );

    i2s_serializer #(.SAMPLE_W(SAMPLE_W)) u_ser (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .bfall_i  (bfall),
        .load_l_i (load_l),
        .load_r_i (load_r),
        .word_l_i (hold_l),
        .word_r_i (hold_r),
        .sdata_o  (sdata_o)
    );

    assign frame_tick_o = frame;

    // R7
    sdata_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(sdata_o) |-> $fell(bclk_o));
    // R4
    ws_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(ws_o) |-> $fell(bclk_o));

endmodule

// File: tb/i2s_tx_bench.sv
module i2s_tx_bench;
    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] left = '0;
    logic [15:0] right = '0;
    logic        mclk, bclk, ws, sdata, tick;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    i2s_tx u_i2s_tx (
        .clk_i        (clk),
        .rst_i        (rst),
        .left_i       (left),
        .right_i      (right),
        .mclk_o       (mclk),
        .bclk_o       (bclk),
        .ws_o         (ws),
        .sdata_o      (sdata),
        .frame_tick_o (tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: clocks since reset and the words captured per frame
    int          k = 0;
    bit          seen = 0;
    bit          in_rst = 0;
    logic [15:0] cur_l = '0, cur_r = '0, prev_r = '0;
    logic        last_sdata = 1'b0;

    always @(posedge clk) begin
        seen = 1;
        if (rst) begin
            k = 0; cur_l = '0; cur_r = '0; prev_r = '0; in_rst = 1;
        end else begin
            in_rst = 0;
            if (k % 1024 == 0) begin
                prev_r = cur_r; cur_l = left; cur_r = right;
            end
            k++;
        end
    end

    function automatic logic exp_sdata(int p);
        if (p >= 32 && p < 544) return cur_l[15 - (p - 32) / 32];
        if (p >= 544)           return cur_r[15 - (p - 544) / 32];
        if (p == 0)             return cur_r[0];
        return prev_r[0];
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%b expected=%b cycle=%0d", tag, act, exp, k);
        end
    endtask

    always @(negedge clk) begin
        if (seen && !done) begin
            int p;
            p = k % 1024;
            if (in_rst) begin
                chk("R1 mclk", mclk, 1'b1);
                chk("R1 bclk", bclk, 1'b0);
                chk("R1 ws", ws, 1'b0);
                chk("R1 sdata", sdata, 1'b0);
                chk("R1 tick", tick, 1'b1);
            end else begin
                chk("R3 mclk", mclk, ((p >> 1) & 1) == 0);
                chk("R2 bclk", bclk, ((p >> 4) & 1) == 1);
                chk("R4 ws", ws, ((p >> 9) & 1) == 1);
                chk("R8 tick", tick, p == 0);
                if (p >= 32 && p < 544) chk("R5 sdata", sdata, exp_sdata(p));
                else                    chk("R6 sdata", sdata, exp_sdata(p));
                if (p % 32 != 0) chk("R7 sdata stable", sdata, last_sdata);
            end
            last_sdata = sdata;
        end
    end

    task automatic hold_words(logic [15:0] l, logic [15:0] r, int n);
        @(negedge clk);
        left = l; right = r;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] lf;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        hold_words(16'h8000, 16'h0001, 3 * 1024);   // R5 R6 alignment
        hold_words(16'hA5C3, 16'h3C5A, 2 * 1024);   // bit and channel order
        hold_words(16'hFFFF, 16'h0000, 2 * 1024);
        hold_words(16'h0000, 16'hFFFF, 2 * 1024);
        // R8: inputs change every cycle, only the frame-edge value matters
        lf = 16'hACE1;
        for (int i = 0; i < 3 * 1024; i++) begin
            @(negedge clk);
            lf = lf ^ (lf << 7); lf = lf ^ (lf >> 9); lf = lf ^ (lf << 8);
            left = lf; right = ~{lf[7:0], lf[15:8]};
        end
        // R1: reset in mid-frame
        hold_words(16'h1234, 16'h8765, 300);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hold_words(16'h7FFF, 16'h8000, 2 * 1024 + 100);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule